// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table held in memory. Given an 8-bit virtual page number and the base address of the page directory, it issues at most two dependent reads. The first read fetches a directory entry. That entry gives the frame that holds one page of the page table. The second read fetches the leaf entry from that page.

The walk produces exactly one of three outcomes. A good walk returns a frame number and protection bits that the translation cache can install before the access is retried. An invalid-access fault is raised when either entry has its valid bit clear. A page-not-present fault is raised when a valid leaf entry marks its page as swapped out.

Memory is reached through a one-cycle request strobe with an address. Read data comes back on a data-valid strobe after any number of cycles. The walker takes a new miss only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1, and `mem_req` and `res_valid` are 0.
- R2: One cycle after a miss is accepted, `mem_req` is 1 for one cycle with `mem_addr` = base + (vpn[7:4] * 4). The base used is the one sampled when the miss was accepted.
- R3: A directory entry whose bit 0 (valid) is 0 ends the walk after that single read with `res_kind` = 2'b01 (invalid access), whatever its other bits hold.
- R4: The leaf read uses `mem_addr` = (directory entry bits 15:8 << 6) + (vpn[3:0] * 4).
- R5: A leaf entry with bit 0 = 0 gives `res_kind` = 2'b01, whatever its other bits hold.
- R6: A leaf entry with bit 0 = 1 and bit 1 (present) = 0 gives `res_kind` = 2'b10 (page not present).
- R7: A leaf entry with bits 1:0 = 2'b11 gives `res_kind` = 2'b00, `res_pfn` = entry bits 15:8 and `res_prot` = entry bits 3:2.
- R8: On either fault, `res_pfn` and `res_prot` are 0. The present bit of a directory entry has no effect on the walk.
- R9: While a walk is in progress, `miss_ready` is 0 and `miss_valid` is ignored. No extra walk starts, and the reported `res_vpn` is the accepted page number.
- R10: The walker waits any number of cycles for `mem_rvalid`, and issues the next request only after the pending read has returned.
- R11: `res_valid` is high for exactly one cycle per walk, with `res_vpn` equal to the accepted page number. The walker is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | 8 | Virtual page number that missed |
| miss_ready | output | 1 | High when idle and able to accept a miss |
| pd_base | input | 16 | Page-directory base byte address |
| mem_req | output | 1 | One-cycle read request strobe |
| mem_addr | output | 16 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 16 | Entry read from memory |
| res_valid | output | 1 | Walk result strobe |
| res_kind | output | 2 | 00 translation, 01 invalid access, 10 not present |
| res_vpn | output | 8 | Page number of this result |
| res_pfn | output | 8 | Frame number (0 on fault) |
| res_prot | output | 2 | Protection bits (0 on fault) |

## Verification
The bench fills a sparse memory with directory entries that are invalid but otherwise all ones, with leaf entries that are invalid but marked present, and with leaf entries that are valid but absent and carry junk in their high bits. A walker that decodes bits other than the valid bit first would report a translation or the wrong fault for these entries. Every request address is checked against the two formulas, including the last directory slot and the last table slot. A swapped shift, or a missing entry-size multiply, would fetch the wrong word. A directory-invalid walk must finish after one read, so a walker that goes on to a second read is caught by the request count. Read latency varies from zero to three idle cycles. While each walk is busy the bench raises a stray miss with a different page number and changes the base register, which catches a walker that takes a new miss in the middle of a walk or does not hold the base it captured.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_FETCH_PDE = 3'd1,
      ST_WAIT_PDE  = 3'd2,
      ST_FETCH_PTE = 3'd3,
      ST_WAIT_PTE  = 3'd4,
      ST_DONE      = 3'd5
   } walk_state_t;

   typedef enum logic [1:0] {
      RES_OK      = 2'b00,
      RES_INVALID = 2'b01,
      RES_ABSENT  = 2'b10
   } walk_res_t;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int ADDR_W      = 16,
   parameter int VPN_W       = 8,
   parameter int DIR_W       = 4,
   parameter int OFF_W       = 6,
   parameter int ENTRY_BYTES = 4,
   parameter int PFN_W       = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [VPN_W-1:0]  vpn,
   input  logic [PFN_W-1:0]  dir_pfn,
   output logic [ADDR_W-1:0] pde_addr,
   output logic [ADDR_W-1:0] pte_addr
);
   localparam int TBL_W  = VPN_W - DIR_W;
   localparam int ENT_SH = $clog2(ENTRY_BYTES);
   localparam bit ENT_P2 = ((1 << ENT_SH) == ENTRY_BYTES);

   logic [DIR_W-1:0]  dir_idx;
   logic [TBL_W-1:0]  tbl_idx;
   logic [ADDR_W-1:0] page_base;
   logic [ADDR_W-1:0] dir_off;
   logic [ADDR_W-1:0] tbl_off;

   assign dir_idx   = vpn[VPN_W-1 -: DIR_W];
   assign tbl_idx   = vpn[TBL_W-1:0];
   assign page_base = ADDR_W'(dir_pfn) << OFF_W;

   generate
      if (ENT_P2) begin : g_shift_scale
         assign dir_off = ADDR_W'(dir_idx) << ENT_SH;
         assign tbl_off = ADDR_W'(tbl_idx) << ENT_SH;
      end else begin : g_mult_scale
         assign dir_off = ADDR_W'(dir_idx) * ADDR_W'(ENTRY_BYTES);
         assign tbl_off = ADDR_W'(tbl_idx) * ADDR_W'(ENTRY_BYTES);
      end
   endgenerate

   assign pde_addr = base + dir_off;
   assign pte_addr = page_base + tbl_off;

   generate
      if (PFN_W + OFF_W > ADDR_W) begin : g_bad_frame_width
         $error("pt_addr_gen: shifted frame number does not fit the address");
      end
      if (DIR_W >= VPN_W) begin : g_bad_dir_width
         $error("pt_addr_gen: directory index must leave table index bits");
      end
   endgenerate
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
   parameter int ENTRY_W  = 16,
   parameter int VLD_BIT  = 0,
   parameter int PRS_BIT  = 1,
   parameter int PROT_LSB = 2,
   parameter int PROT_W   = 2,
   parameter int PFN_LSB  = 8,
   parameter int PFN_W    = 8
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               ent_valid,
   output logic               ent_present,
   output logic [PROT_W-1:0]  ent_prot,
   output logic [PFN_W-1:0]   ent_pfn
);
   logic unused_entry_bits;

   assign ent_valid   = entry[VLD_BIT];
   assign ent_present = entry[PRS_BIT];
   assign ent_prot    = entry[PROT_LSB +: PROT_W];
   assign ent_pfn     = entry[PFN_LSB +: PFN_W];
   assign unused_entry_bits = ^entry;

   generate
      if (PFN_LSB + PFN_W > ENTRY_W) begin : g_bad_pfn_field
         $error("pt_entry_decode: frame field exceeds entry width");
      end
      if (PROT_LSB + PROT_W > PFN_LSB) begin : g_bad_prot_field
         $error("pt_entry_decode: protection field overlaps frame field");
      end
      if (VLD_BIT == PRS_BIT) begin : g_bad_flag_bits
         $error("pt_entry_decode: valid and present bits must differ");
      end
   endgenerate
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int VPN_W  = 8,
   parameter int PFN_W  = 8,
   parameter int PROT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   input  logic [ADDR_W-1:0] pd_base,
   output logic              miss_ready,
   input  logic              mem_rvalid,
   input  logic              ent_valid,
   input  logic              ent_present,
   input  logic [PROT_W-1:0] ent_prot,
   input  logic [PFN_W-1:0]  ent_pfn,
   input  logic [ADDR_W-1:0] pde_addr,
   input  logic [ADDR_W-1:0] pte_addr,
   output logic [VPN_W-1:0]  vpn_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [PFN_W-1:0]  dir_pfn_q,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              res_valid,
   output logic [1:0]        res_kind,
   output logic [PFN_W-1:0]  res_pfn,
   output logic [PROT_W-1:0] res_prot
);
   walk_state_t       state;
   walk_res_t         kind_q;
   logic [PFN_W-1:0]  rpfn_q;
   logic [PROT_W-1:0] rprot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         vpn_q     <= '0;
         base_q    <= '0;
         dir_pfn_q <= '0;
         kind_q    <= RES_OK;
         rpfn_q    <= '0;
         rprot_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (miss_valid) begin
                  vpn_q  <= miss_vpn;
                  base_q <= pd_base;
                  state  <= ST_FETCH_PDE;
               end
            end
            ST_FETCH_PDE: state <= ST_WAIT_PDE;
            ST_WAIT_PDE: begin
               if (mem_rvalid) begin
                  if (!ent_valid) begin
                     kind_q  <= RES_INVALID;
                     rpfn_q  <= '0;
                     rprot_q <= '0;
                     state   <= ST_DONE;
                  end else begin
                     dir_pfn_q <= ent_pfn;
                     state     <= ST_FETCH_PTE;
                  end
               end
            end
            ST_FETCH_PTE: state <= ST_WAIT_PTE;
            ST_WAIT_PTE: begin
               if (mem_rvalid) begin
                  state <= ST_DONE;
                  if (!ent_valid) begin
                     kind_q  <= RES_INVALID;
                     rpfn_q  <= '0;
                     rprot_q <= '0;
                  end else if (!ent_present) begin
                     kind_q  <= RES_ABSENT;
                     rpfn_q  <= '0;
                     rprot_q <= '0;
                  end else begin
                     kind_q  <= RES_OK;
                     rpfn_q  <= ent_pfn;
                     rprot_q <= ent_prot;
                  end
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (state == ST_FETCH_PDE) || (state == ST_FETCH_PTE);
      mem_addr = (state == ST_FETCH_PTE) ? pte_addr : pde_addr;
   end

   assign miss_ready = (state == ST_IDLE);
   assign res_valid  = (state == ST_DONE);
   assign res_kind   = kind_q;
   assign res_pfn    = rpfn_q;
   assign res_prot   = rprot_q;

   p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_busy_holds_vpn_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_ready |=> $stable(vpn_q) && $stable(base_q));

   p_res_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid && miss_ready);

   p_bad_pde_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_PDE && mem_rvalid && !ent_valid) |=>
         res_valid && res_kind == RES_INVALID && !mem_req);

   p_kind_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_kind != 2'b11);

   p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind != RES_OK) |-> (res_pfn == '0 && res_prot == '0));

   p_accept_then_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_ready && miss_valid) |=> mem_req && !miss_ready);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int ADDR_W      = 16,
   parameter int VPN_W       = 8,
   parameter int DIR_W       = 4,
   parameter int OFF_W       = 6,
   parameter int ENTRY_BYTES = 4,
   parameter int ENTRY_W     = 16,
   parameter int PFN_LSB     = 8,
   parameter int PFN_W       = 8,
   parameter int PROT_LSB    = 2,
   parameter int PROT_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] pd_base,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [ENTRY_W-1:0] mem_rdata,
   output logic              res_valid,
   output logic [1:0]        res_kind,
   output logic [VPN_W-1:0]  res_vpn,
   output logic [PFN_W-1:0]  res_pfn,
   output logic [PROT_W-1:0] res_prot
);
   logic              ent_valid;
   logic              ent_present;
   logic [PROT_W-1:0] ent_prot;
   logic [PFN_W-1:0]  ent_pfn;
   logic [ADDR_W-1:0] pde_addr;
   logic [ADDR_W-1:0] pte_addr;
   logic [VPN_W-1:0]  vpn_q;
   logic [ADDR_W-1:0] base_q;
   logic [PFN_W-1:0]  dir_pfn_q;

   generate
      if (ENTRY_BYTES * 8 < ENTRY_W) begin : g_bad_entry_size
         $error("pt_walker: entry wider than its byte size");
      end
   endgenerate

   pt_entry_decode #(
      .ENTRY_W (ENTRY_W),
      .VLD_BIT (0),
      .PRS_BIT (1),
      .PROT_LSB(PROT_LSB),
      .PROT_W  (PROT_W),
      .PFN_LSB (PFN_LSB),
      .PFN_W   (PFN_W)
   ) u_dec (
      .entry      (mem_rdata),
      .ent_valid  (ent_valid),
      .ent_present(ent_present),
      .ent_prot   (ent_prot),
      .ent_pfn    (ent_pfn)
   );

   pt_addr_gen #(
      .ADDR_W     (ADDR_W),
      .VPN_W      (VPN_W),
      .DIR_W      (DIR_W),
      .OFF_W      (OFF_W),
      .ENTRY_BYTES(ENTRY_BYTES),
      .PFN_W      (PFN_W)
   ) u_agen (
      .base    (base_q),
      .vpn     (vpn_q),
      .dir_pfn (dir_pfn_q),
      .pde_addr(pde_addr),
      .pte_addr(pte_addr)
   );

   pt_walk_ctrl #(
      .ADDR_W(ADDR_W),
      .VPN_W (VPN_W),
      .PFN_W (PFN_W),
      .PROT_W(PROT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_vpn   (miss_vpn),
      .pd_base    (pd_base),
      .miss_ready (miss_ready),
      .mem_rvalid (mem_rvalid),
      .ent_valid  (ent_valid),
      .ent_present(ent_present),
      .ent_prot   (ent_prot),
      .ent_pfn    (ent_pfn),
      .pde_addr   (pde_addr),
      .pte_addr   (pte_addr),
      .vpn_q      (vpn_q),
      .base_q     (base_q),
      .dir_pfn_q  (dir_pfn_q),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .res_valid  (res_valid),
      .res_kind   (res_kind),
      .res_pfn    (res_pfn),
      .res_prot   (res_prot)
   );

   assign res_vpn = vpn_q;
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [7:0]  miss_vpn = '0;
   logic        miss_ready;
   logic [15:0] pd_base = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [7:0]  res_vpn;
   logic [7:0]  res_pfn;
   logic [1:0]  res_prot;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker u0 (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
      .miss_ready(miss_ready), .pd_base(pd_base), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_kind(res_kind), .res_vpn(res_vpn),
      .res_pfn(res_pfn), .res_prot(res_prot)
   );

   typedef struct {
      logic [1:0] kind;
      logic [7:0] vpn;
      logic [7:0] pfn;
      logic [1:0] prot;
      string      tag;
   } exp_res_t;

   typedef struct {
      logic [15:0] addr;
      string       tag;
   } exp_addr_t;

   exp_res_t    res_q[$];
   exp_addr_t   addr_q[$];
   logic [15:0] mem_img [int];

   int n_checks = 0;
   int n_fail   = 0;
   int req_count = 0;
   int lat_seed  = 0;
   bit pend = 1'b0;
   int wait_n = 0;
   logic [15:0] rd_word = '0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // memory responder with variable latency (R10)
   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (pend) begin
         if (wait_n == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_word;
            pend       = 1'b0;
         end else begin
            wait_n--;
         end
      end
      if (rst_n && mem_req) begin
         exp_addr_t ea;
         req_count++;
         if (addr_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected request", int'(mem_addr), 0);
         end else begin
            ea = addr_q.pop_front();
            chk(mem_addr == ea.addr, ea.tag, "request address",
                int'(mem_addr), int'(ea.addr));
         end
         chk(!pend, "R10", "request while read pending", 1, 0);
         rd_word = mem_img.exists(int'(mem_addr)) ? mem_img[int'(mem_addr)] : 16'h0000;
         pend    = 1'b1;
         wait_n  = lat_seed % 4;
         lat_seed++;
      end
   end

   // result monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         exp_res_t er;
         if (res_q.size() == 0) begin
            chk(1'b0, "R11", "result with nothing expected", 1, 0);
         end else begin
            er = res_q.pop_front();
            chk(res_kind == er.kind, er.tag, "result kind", int'(res_kind), int'(er.kind));
            chk(res_vpn == er.vpn, "R11", "result vpn", int'(res_vpn), int'(er.vpn));
            chk(res_pfn == er.pfn, er.tag, "result pfn", int'(res_pfn), int'(er.pfn));
            chk(res_prot == er.prot, er.tag, "result prot", int'(res_prot), int'(er.prot));
         end
      end
   end

   task automatic walk(input logic [7:0] vpn, input logic [15:0] base,
                       input logic [7:0] pde_pfn, input bit two_reads,
                       input logic [1:0] kind, input logic [7:0] pfn,
                       input logic [1:0] prot, input string tag);
      exp_addr_t a0;
      exp_addr_t a1;
      exp_res_t  er;
      int        rc0;
      a0.addr = base + 16'({4'h0, vpn[7:4]}) * 16'd4;
      a0.tag  = "R2";
      addr_q.push_back(a0);
      if (two_reads) begin
         a1.addr = (16'(pde_pfn) << 6) + 16'({4'h0, vpn[3:0]}) * 16'd4;
         a1.tag  = "R4";
         addr_q.push_back(a1);
      end
      er.kind = kind; er.vpn = vpn; er.pfn = pfn; er.prot = prot; er.tag = tag;
      res_q.push_back(er);
      while (!miss_ready) @(negedge clk);
      rc0 = req_count;
      miss_valid = 1'b1;
      miss_vpn   = vpn;
      pd_base    = base;
      @(negedge clk);
      // stray miss and base change while busy (R9)
      chk(!miss_ready, "R9", "ready while busy", int'(miss_ready), 0);
      miss_vpn = ~vpn;
      pd_base  = 16'hF000;
      @(negedge clk);
      miss_valid = 1'b0;
      while (!res_valid) @(negedge clk);
      @(negedge clk);
      chk(miss_ready && !res_valid, "R11", "idle after result",
          int'({miss_ready, res_valid}), 2);
      chk(!mem_req, "R9", "walk started by stray miss", int'(mem_req), 0);
      chk(req_count - rc0 == (two_reads ? 2 : 1), two_reads ? "R4" : "R3",
          "read count", req_count - rc0, two_reads ? 2 : 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // directory at 0x0400
      mem_img[16'h040C] = 16'h2001;  // dir 3: valid, frame 0x20, present bit clear (R8)
      mem_img[16'h0428] = 16'hFFFE;  // dir A: invalid, all other bits set (R3)
      mem_img[16'h043C] = 16'h3F01;  // dir F: frame 0x3F
      // leaf page at 0x0800
      mem_img[16'h0814] = 16'h9A0B;  // ok, pfn 9A, prot 2
      mem_img[16'h0818] = 16'h55F1;  // valid, not present
      mem_img[16'h081C] = 16'h77FE;  // invalid, present set
      mem_img[16'h083C] = 16'hFF0F;  // ok, pfn FF, prot 3
      mem_img[16'h0800] = 16'h0103;  // ok, pfn 01, prot 0
      mem_img[16'h0FF8] = 16'h4407;  // ok, pfn 44, prot 1
      // second directory at 0x2000
      mem_img[16'h200C] = 16'h2101;
      mem_img[16'h0854] = 16'h1207;

      repeat (3) @(negedge clk);
      chk(miss_ready == 1'b1, "R1", "reset ready", int'(miss_ready), 1);
      chk(mem_req == 1'b0, "R1", "reset mem_req", int'(mem_req), 0);
      chk(res_valid == 1'b0, "R1", "reset res_valid", int'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      walk(8'h35, 16'h0400, 8'h20, 1'b1, 2'b00, 8'h9A, 2'd2, "R7");
      walk(8'h36, 16'h0400, 8'h20, 1'b1, 2'b10, 8'h00, 2'd0, "R6");
      walk(8'h37, 16'h0400, 8'h20, 1'b1, 2'b01, 8'h00, 2'd0, "R5");
      walk(8'hA5, 16'h0400, 8'h00, 1'b0, 2'b01, 8'h00, 2'd0, "R3");
      walk(8'h3F, 16'h0400, 8'h20, 1'b1, 2'b00, 8'hFF, 2'd3, "R7");
      walk(8'h30, 16'h0400, 8'h20, 1'b1, 2'b00, 8'h01, 2'd0, "R8");
      walk(8'hFE, 16'h0400, 8'h3F, 1'b1, 2'b00, 8'h44, 2'd1, "R4");
      walk(8'h05, 16'h0400, 8'h00, 1'b0, 2'b01, 8'h00, 2'd0, "R3");
      walk(8'h35, 16'h2000, 8'h21, 1'b1, 2'b00, 8'h12, 2'd1, "R2");
      walk(8'h36, 16'h0400, 8'h20, 1'b1, 2'b10, 8'h00, 2'd0, "R10");

      repeat (3) @(negedge clk);
      chk(res_q.size() == 0, "R11", "results outstanding", res_q.size(), 0);
      chk(addr_q.size() == 0, "R10", "reads outstanding", addr_q.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule